// File: doc/BRIEF.md
# DDR Bank State and Timing Guard

This block sits on the controller side of a four-bank DDR SDRAM and tracks every bank so that a command can be judged before it is put on the command bus. The scheduler presents one decoded command per cycle (activate, read, write, precharge, burst stop or no-op, together with the bank, the row and the auto-precharge bit carried on A10). The block answers in the same cycle whether the command is legal now and, if it is not, gives a reason code. When `cmd_valid` is high and the command is legal, the bank trackers take the command on the next rising edge. A rejected command leaves every bank as it was.

Each bank runs its own four-state machine. The states are `BK_IDLE`, `BK_OPEN`, `BK_APWAIT` (an auto-precharge is scheduled) and `BK_CLOSING` (a precharge is running). The transitions are: *activate* moves IDLE or a finished CLOSING to OPEN. *Precharge* moves OPEN to CLOSING. A *read or write with auto-precharge* moves OPEN to APWAIT. *Auto-start* moves APWAIT to CLOSING once the delay has run out and tRAS is met. *Recover* moves CLOSING to IDLE when tRP has run out. Every bank has its own counters for tRCD, tRAS, tRP and the auto-precharge delay. One counter shared by all banks enforces tRRD.

A separate read-window tracker follows the read data slot on the bus. A burst stop cuts that slot short.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset all banks are closed (`bank_open` = 0), `rd_busy` is 0, and an activate to any bank is legal with reason 0.
- R2: An activate (op 1) to an idle bank is legal, opens the bank on the next edge and records its row, which `bank_row` then shows for that bank. An activate to an open bank, or to a bank with an auto-precharge scheduled, is rejected with reason 1.
- R3: A read (op 2) or write (op 3) to an open bank is rejected with reason 3 until cfg_trcd cycles after its activate. To a closed or closing bank it is rejected with reason 2.
- R4: An activate that comes fewer than cfg_trrd cycles after the previous accepted activate is rejected with reason 4.
- R5: A precharge (op 4, A10 low) to an open bank is rejected with reason 5 until cfg_tras cycles after its activate. Once accepted it closes the bank. A new activate to that bank is rejected with reason 6 until cfg_trp cycles after the precharge edge.
- R6: A precharge with A10 high closes every open bank whatever the bank field says. It is rejected with reason 5 if any open bank has not yet met tRAS.
- R7: A read with A10 high schedules an auto-precharge. The bank closes at the edge cfg_cl + burst clocks after the read, or at the edge where tRAS is met if that comes later. Until then a read or write to that bank is rejected with reason 7. Afterwards tRP applies as in R5.
- R8: A write with A10 high closes its bank at the edge 1 + burst clocks after the write, because write data starts one clock after the command.
- R9: `rd_busy` is high in the cycles that follow edges r+cfg_cl through r+cfg_cl+burst−1 after a read accepted at edge r. The number of burst clocks is 1, 2 or 4 for cfg_burst 0, 1 or 2. A read issued exactly one burst after another read gives a window with no gap.
- R10: A burst stop (op 5) accepted at edge b during a read burst makes `rd_busy` low from edge b+cfg_cl on. When no read burst is issuing (for example after a write) it has no effect.
- R11: A rejected command changes no bank state and no stored row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command is issued this cycle if legal |
| cmd_op | input | 3 | 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | A10: auto-precharge on read/write, all banks on precharge |
| cmd_row | input | 13 | Row for activate |
| cfg_cl | input | 3 | CAS latency in clocks (1..4) |
| cfg_burst | input | 2 | Burst code: 0 = 2 beats, 1 = 4 beats, 2 = 8 beats |
| cfg_trcd | input | 5 | tRCD in clocks |
| cfg_trrd | input | 5 | tRRD in clocks |
| cfg_trp | input | 5 | tRP in clocks |
| cfg_tras | input | 5 | tRAS in clocks |
| cmd_ok | output | 1 | Presented command is legal now |
| cmd_reason | output | 3 | 0 ok, 1 busy, 2 closed, 3 tRCD, 4 tRRD, 5 tRAS, 6 tRP, 7 auto-precharge pending |
| bank_open | output | 4 | One bit per bank, set while the row is open |
| bank_row | output | 13 | Stored row of the bank named by cmd_bank |
| rd_busy | output | 1 | Read data slot occupied on the bus |

## Verification
`cmd_ok` and `cmd_reason` are combinational, so the bench drives a command just after a falling edge and reads the verdict before the next rising edge. `bank_open` and `bank_row` change on the edge that accepts a command, so they are read 1 ns after that edge. Auto-precharge closure and the `rd_busy` window are due a computed number of edges later. The expected edge is counted from the accepting edge using cfg_cl, the burst clocks and tRAS, and the bench checks the cycle just before that edge and the cycle just after it.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_BST = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        RS_OK     = 3'd0,
        RS_BUSY   = 3'd1,
        RS_CLOSED = 3'd2,
        RS_TRCD   = 3'd3,
        RS_TRRD   = 3'd4,
        RS_TRAS   = 3'd5,
        RS_TRP    = 3'd6,
        RS_APPEND = 3'd7
    } reason_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_APWAIT  = 2'd2,
        BK_CLOSING = 2'd3
    } bank_st_e;

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_guard_pkg::*;
#(
    parameter int TW    = 5,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic [TW-1:0]    cfg_tras,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    ap_dly,
    input  logic             go_act,
    input  logic             go_col,
    input  logic             go_col_ap,
    input  logic             go_pre,
    input  logic [ROW_W-1:0] act_row,
    output bank_st_e         st,
    output logic             rcd_ok,
    output logic             ras_ok,
    output logic             rp_ok,
    output logic [ROW_W-1:0] row_q
);

    bank_st_e      st_q, st_nx;
    logic [TW-1:0] rcd_cnt, ras_cnt, rp_cnt, ap_cnt;
    logic          enter_closing;

    function automatic logic [TW-1:0] less1(input logic [TW-1:0] x);
        return (x == '0) ? '0 : x - 1'b1;
    endfunction

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            BK_IDLE:    if (go_act) st_nx = BK_OPEN;
            BK_OPEN: begin
                if (go_pre)                 st_nx = BK_CLOSING;
                else if (go_col && go_col_ap) st_nx = BK_APWAIT;
            end
            BK_APWAIT:  if (ap_cnt == '0 && ras_cnt == '0) st_nx = BK_CLOSING;
            BK_CLOSING: begin
                if (go_act)            st_nx = BK_OPEN;
                else if (rp_cnt == '0) st_nx = BK_IDLE;
            end
        endcase
    end

    assign enter_closing = (st_nx == BK_CLOSING) && (st_q != BK_CLOSING);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BK_IDLE;
        else        st_q <= st_nx;
    end

    // window counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            ras_cnt <= '0;
            rp_cnt  <= '0;
            ap_cnt  <= '0;
            row_q   <= '0;
        end else begin
            if (go_act) begin
                rcd_cnt <= less1(cfg_trcd);
                ras_cnt <= less1(cfg_tras);
                row_q   <= act_row;
            end else begin
                rcd_cnt <= less1(rcd_cnt);
                ras_cnt <= less1(ras_cnt);
            end
            if (enter_closing) rp_cnt <= less1(cfg_trp);
            else               rp_cnt <= less1(rp_cnt);
            if (go_col && go_col_ap) ap_cnt <= less1(ap_dly);
            else                     ap_cnt <= less1(ap_cnt);
        end
    end

    // outputs
    always_comb begin
        st     = st_q;
        rcd_ok = (rcd_cnt == '0);
        ras_ok = (ras_cnt == '0);
        rp_ok  = (rp_cnt == '0);
    end

    // R3
    col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_col |-> (st_q == BK_OPEN && rcd_cnt == '0));

    // R5
    no_early_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == BK_OPEN || st_q == BK_APWAIT) && ras_cnt != '0) |=> st_q != BK_CLOSING);

    // R7
    no_col_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_APWAIT) |-> !go_col);

    // R11
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_act |=> $stable(row_q));

endmodule

// File: rtl/ddr_rd_window.sv
module ddr_rd_window #(
    parameter int CL_MAX = 4,
    parameter int CLW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_go,
    input  logic           bst_go,
    input  logic [3:0]     burst_clk,
    input  logic [CLW-1:0] cfg_cl,
    output logic           rd_busy
);

    localparam int TAPW = (CL_MAX > 1) ? $clog2(CL_MAX) : 1;

    logic [3:0]        left_q;
    logic [CL_MAX-1:0] sr_q;
    logic [TAPW-1:0]   tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            sr_q   <= '0;
        end else begin
            if (rd_go)                         left_q <= burst_clk;
            else if (bst_go && left_q != '0)   left_q <= '0;
            else if (left_q != '0)             left_q <= left_q - 1'b1;
            sr_q <= {sr_q[CL_MAX-2:0], (left_q != '0)};
        end
    end

    always_comb begin
        if (cfg_cl == '0)                 tap = '0;
        else if (int'(cfg_cl) > CL_MAX)   tap = TAPW'(CL_MAX - 1);
        else                              tap = TAPW'(cfg_cl - 1'b1);
        rd_busy = sr_q[tap];
    end

    // R9
    issue_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> left_q <= $past(left_q));

    // R10
    bst_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_go && !rd_go) |=> left_q == '0);

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_guard_pkg::*;
#(
    parameter int NB     = 4,
    parameter int ROW_W  = 13,
    parameter int TW     = 5,
    parameter int CL_MAX = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [$clog2(NB)-1:0] cmd_bank,
    input  logic                  cmd_ap,
    input  logic [ROW_W-1:0]      cmd_row,
    input  logic [$clog2(CL_MAX+1)-1:0] cfg_cl,
    input  logic [1:0]            cfg_burst,
    input  logic [TW-1:0]         cfg_trcd,
    input  logic [TW-1:0]         cfg_trrd,
    input  logic [TW-1:0]         cfg_trp,
    input  logic [TW-1:0]         cfg_tras,
    output logic                  cmd_ok,
    output logic [2:0]            cmd_reason,
    output logic [NB-1:0]         bank_open,
    output logic [ROW_W-1:0]      bank_row,
    output logic                  rd_busy
);

    localparam int BW  = $clog2(NB);
    localparam int CLW = $clog2(CL_MAX + 1);

    op_e             op;
    reason_e         why;
    bank_st_e        st   [NB];
    logic [NB-1:0]   rcd_ok, ras_ok, rp_ok;
    logic [ROW_W-1:0] rows [NB];
    logic [3:0]      burst_clk;
    logic [TW-1:0]   ap_dly;
    logic [TW-1:0]   rrd_cnt;
    logic            acc, acc_act;

    assign op = op_e'(cmd_op);

    always_comb begin
        unique case (cfg_burst)
            2'd0:    burst_clk = 4'd1;
            2'd1:    burst_clk = 4'd2;
            default: burst_clk = 4'd4;
        endcase
        if (op == OP_RD) ap_dly = TW'(burst_clk) + TW'(cfg_cl);
        else             ap_dly = TW'(burst_clk) + TW'(1);
    end

    // legality judge
    always_comb begin
        why = RS_OK;
        unique case (op)
            OP_ACT: begin
                unique case (st[cmd_bank])
                    BK_IDLE:    why = RS_OK;
                    BK_CLOSING: why = rp_ok[cmd_bank] ? RS_OK : RS_TRP;
                    BK_OPEN, BK_APWAIT: why = RS_BUSY;
                endcase
                if (why == RS_OK && rrd_cnt != '0) why = RS_TRRD;
            end
            OP_RD, OP_WR: begin
                unique case (st[cmd_bank])
                    BK_OPEN:   why = rcd_ok[cmd_bank] ? RS_OK : RS_TRCD;
                    BK_APWAIT: why = RS_APPEND;
                    BK_IDLE, BK_CLOSING: why = RS_CLOSED;
                endcase
            end
            OP_PRE: begin
                for (int i = 0; i < NB; i++) begin
                    if (cmd_ap || BW'(i) == cmd_bank) begin
                        if (st[i] == BK_APWAIT && why == RS_OK)
                            why = RS_APPEND;
                        else if (st[i] == BK_OPEN && !ras_ok[i] && why == RS_OK)
                            why = RS_TRAS;
                    end
                end
            end
            default: why = RS_OK;
        endcase
    end

    assign cmd_ok     = (why == RS_OK);
    assign cmd_reason = why;
    assign acc        = cmd_valid && cmd_ok;
    assign acc_act    = acc && op == OP_ACT;

    // shared tRRD counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rrd_cnt <= '0;
        else if (acc_act)    rrd_cnt <= (cfg_trrd == '0) ? '0 : cfg_trrd - 1'b1;
        else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - 1'b1;
    end

    generate
        for (genvar g = 0; g < NB; g++) begin : g_bank
            logic sel;
            assign sel = (cmd_bank == BW'(g));
            ddr_bank_track #(.TW(TW), .ROW_W(ROW_W)) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_trcd  (cfg_trcd),
                .cfg_tras  (cfg_tras),
                .cfg_trp   (cfg_trp),
                .ap_dly    (ap_dly),
                .go_act    (acc_act && sel),
                .go_col    (acc && (op == OP_RD || op == OP_WR) && sel),
                .go_col_ap (cmd_ap),
                .go_pre    (acc && op == OP_PRE && (sel || cmd_ap)),
                .act_row   (cmd_row),
                .st        (st[g]),
                .rcd_ok    (rcd_ok[g]),
                .ras_ok    (ras_ok[g]),
                .rp_ok     (rp_ok[g]),
                .row_q     (rows[g])
            );
            assign bank_open[g] = (st[g] == BK_OPEN) || (st[g] == BK_APWAIT);
        end
    endgenerate

    assign bank_row = rows[cmd_bank];

    ddr_rd_window #(.CL_MAX(CL_MAX), .CLW(CLW)) u_rdw (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (acc && op == OP_RD),
        .bst_go    (acc && op == OP_BST),
        .burst_clk (burst_clk),
        .cfg_cl    (cfg_cl),
        .rd_busy   (rd_busy)
    );

    // R4
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_act && cfg_trrd > TW'(1)) |=> !acc_act);

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_act |=> bank_open[$past(cmd_bank)]);

endmodule

// File: tb/ddr_bank_guard_bench.sv
`timescale 1ns/100ps
module ddr_bank_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic        cmd_ap;
    logic [12:0] cmd_row;
    logic [2:0]  cfg_cl;
    logic [1:0]  cfg_burst;
    logic [4:0]  cfg_trcd, cfg_trrd, cfg_trp, cfg_tras;
    logic        cmd_ok;
    logic [2:0]  cmd_reason;
    logic [3:0]  bank_open;
    logic [12:0] bank_row;
    logic        rd_busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ddr_bank_guard u_ddr_bank_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_row(cmd_row),
        .cfg_cl(cfg_cl), .cfg_burst(cfg_burst), .cfg_trcd(cfg_trcd),
        .cfg_trrd(cfg_trrd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cmd_ok(cmd_ok), .cmd_reason(cmd_reason), .bank_open(bank_open),
        .bank_row(bank_row), .rd_busy(rd_busy)
    );

    // {op, bank, ap, row, ok, reason, open-after-edge}; cl=2, burst 4, trcd=2, trrd=2, trp=2, tras=4
    localparam logic [17:0] VEC [20] = '{
        {3'd1, 2'd0, 1'b0, 4'd5, 1'b1, 3'd0, 4'b0001},  // R2 open b0
        {3'd2, 2'd0, 1'b0, 4'd0, 1'b0, 3'd3, 4'b0001},  // R3 tRCD
        {3'd1, 2'd1, 1'b0, 4'd6, 1'b1, 3'd0, 4'b0011},  // R4 tRRD met
        {3'd2, 2'd0, 1'b0, 4'd0, 1'b1, 3'd0, 4'b0011},  // R3 read ok
        {3'd4, 2'd1, 1'b0, 4'd0, 1'b0, 3'd5, 4'b0011},  // R5 tRAS
        {3'd2, 2'd2, 1'b0, 4'd0, 1'b0, 3'd2, 4'b0011},  // R3 closed
        {3'd4, 2'd0, 1'b0, 4'd0, 1'b1, 3'd0, 4'b0010},  // R5 precharge
        {3'd1, 2'd0, 1'b0, 4'd9, 1'b0, 3'd6, 4'b0010},  // R5 tRP
        {3'd1, 2'd0, 1'b0, 4'd9, 1'b1, 3'd0, 4'b0011},  // R5 tRP met
        {3'd1, 2'd3, 1'b0, 4'd2, 1'b0, 3'd4, 4'b0011},  // R4 tRRD
        {3'd1, 2'd3, 1'b0, 4'd2, 1'b1, 3'd0, 4'b1011},  // R4
        {3'd3, 2'd1, 1'b1, 4'd0, 1'b1, 3'd0, 4'b1011},  // R8 write ap
        {3'd2, 2'd1, 1'b0, 4'd0, 1'b0, 3'd7, 4'b1011},  // R7 pending
        {3'd1, 2'd1, 1'b0, 4'd0, 1'b0, 3'd1, 4'b1011},  // R2 busy
        {3'd0, 2'd0, 1'b0, 4'd0, 1'b1, 3'd0, 4'b1001},  // R8 closes at wr+3
        {3'd1, 2'd1, 1'b0, 4'd1, 1'b0, 3'd6, 4'b1001},  // R8 tRP after ap
        {3'd4, 2'd2, 1'b1, 4'd0, 1'b1, 3'd0, 4'b0000},  // R6 all banks
        {3'd1, 2'd1, 1'b0, 4'd1, 1'b1, 3'd0, 4'b0010},  // R6 reopen
        {3'd4, 2'd0, 1'b1, 4'd0, 1'b0, 3'd5, 4'b0010},  // R6 tRAS blocks all
        {3'd5, 2'd0, 1'b0, 4'd0, 1'b1, 3'd0, 4'b0010}   // R10 idle stop
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int op, input int bank, input bit ap, input int row);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_bank  = 2'(bank);
        cmd_ap    = ap;
        cmd_row   = 13'(row);
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input int op, input int bank, input bit ap, input int row);
        put(op, bank, ap, row);
        tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 2'd0;
        cmd_ap = 1'b0; cmd_row = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        finish_run();
    end

    initial begin
        cfg_cl = 3'd2; cfg_burst = 2'd1; cfg_trcd = 5'd2; cfg_trrd = 5'd2;
        cfg_trp = 5'd2; cfg_tras = 5'd4;
        do_reset();

        // R1 reset state
        put(1, 0, 1'b0, 3);
        chk("R1", "bank_open", bank_open, 0);
        chk("R1", "rd_busy", rd_busy, 0);
        chk("R1", "cmd_ok", cmd_ok, 1);
        chk("R1", "reason", cmd_reason, 0);
        do_reset();

        // vector walk
        for (int k = 0; k < 20; k++) begin
            put(int'(VEC[k][17:15]), int'(VEC[k][14:13]), VEC[k][12], int'(VEC[k][11:8]));
            chk($sformatf("vec%0d", k), "cmd_ok", cmd_ok, VEC[k][7]);
            chk($sformatf("vec%0d", k), "reason", cmd_reason, VEC[k][6:4]);
            tick();
            chk($sformatf("vec%0d", k), "bank_open", bank_open, VEC[k][3:0]);
        end

        // R11 rejected activate keeps row and state
        do_reset();
        cyc(1, 2, 1'b0, 7);
        put(1, 2, 1'b0, 3);
        chk("R11", "reason", cmd_reason, 1);
        tick();
        put(0, 2, 1'b0, 0);
        chk("R11", "bank_row", bank_row, 7);
        chk("R11", "bank_open", bank_open, 4'b0100);

        // R7 + R9 read with auto-precharge, cl=2, burst 2 clocks, tras=4
        do_reset();
        cyc(1, 0, 1'b0, 1);            // edge a
        cyc(0, 0, 1'b0, 0);            // a+1
        cyc(2, 0, 1'b1, 0);            // a+2 read ap
        chk("R9", "rd_busy after r", rd_busy, 0);
        put(2, 0, 1'b0, 0);
        chk("R7", "reason pending", cmd_reason, 7);
        cmd_valid = 1'b0;
        tick();                        // a+3 (r+1)
        chk("R9", "rd_busy r+1", rd_busy, 0);
        tick();                        // r+2
        chk("R9", "rd_busy r+2", rd_busy, 1);
        tick();                        // r+3 = a+5
        chk("R9", "rd_busy r+3", rd_busy, 1);
        chk("R7", "open before ap", bank_open[0], 1);
        tick();                        // a+6
        chk("R9", "rd_busy r+4", rd_busy, 0);
        chk("R7", "closed at ap", bank_open[0], 0);
        put(1, 0, 1'b0, 2);
        chk("R7", "tRP after ap", cmd_reason, 6);
        tick();                        // a+7
        put(1, 0, 1'b0, 2);
        chk("R7", "act after tRP", cmd_ok, 1);
        cmd_valid = 1'b0;
        tick();

        // R7 tRAS floor: tras=10
        cfg_tras = 5'd10;
        do_reset();
        cyc(1, 1, 1'b0, 4);            // a
        cyc(0, 0, 1'b0, 0);            // a+1
        cyc(2, 1, 1'b1, 0);            // a+2
        for (int j = 0; j < 6; j++) cyc(0, 0, 1'b0, 0);   // to a+8
        cyc(0, 0, 1'b0, 0);            // a+9
        chk("R7", "held by tRAS", bank_open[1], 1);
        cyc(0, 0, 1'b0, 0);            // a+10
        chk("R7", "closed at tRAS", bank_open[1], 0);
        cfg_tras = 5'd4;

        // R9 gapless reads, R10 burst stop
        do_reset();
        cyc(1, 0, 1'b0, 1);
        cyc(0, 0, 1'b0, 0);
        cyc(2, 0, 1'b0, 0);            // r
        cyc(0, 0, 1'b0, 0);            // r+1
        cyc(2, 0, 1'b0, 0);            // r+2
        chk("R9", "gapless r+2", rd_busy, 1);
        cyc(0, 0, 1'b0, 0);
        chk("R9", "gapless r+3", rd_busy, 1);
        cyc(0, 0, 1'b0, 0);
        chk("R9", "gapless r+4", rd_busy, 1);
        cyc(0, 0, 1'b0, 0);
        chk("R9", "gapless r+5", rd_busy, 1);
        cyc(0, 0, 1'b0, 0);
        chk("R9", "end r+6", rd_busy, 0);

        cfg_burst = 2'd2;
        cyc(2, 0, 1'b0, 0);            // r
        cyc(5, 0, 1'b0, 0);            // r+1 stop
        cyc(0, 0, 1'b0, 0);            // r+2
        chk("R10", "busy before cut", rd_busy, 1);
        cyc(0, 0, 1'b0, 0);            // r+3 = b+cl
        chk("R10", "cut at b+cl", rd_busy, 0);
        for (int j = 0; j < 6; j++) cyc(0, 0, 1'b0, 0);
        cyc(3, 0, 1'b0, 0);            // write
        cyc(5, 0, 1'b0, 0);            // stop during write
        cyc(0, 0, 1'b0, 0);
        chk("R10", "stop in write rd_busy", rd_busy, 0);
        chk("R10", "stop in write bank", bank_open, 4'b0001);
        put(2, 0, 1'b0, 0);
        chk("R10", "bank still readable", cmd_ok, 1);
        cmd_valid = 1'b0;
        tick();

        finish_run();
    end

endmodule